// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

This block sits inside a peripheral and connects it to a shared bus interrupt request line and to an acknowledge line that runs from device to device. A pulse on the local request input makes the block pending, and it then drives its share of the wired-OR request. An acknowledge that arrives while the block is not the requester goes straight on to the next device. If the block is pending when the acknowledge arrives, it keeps the grant to itself. It then places its 8-bit vector on the 16-bit data lines and afterwards withdraws its request. The CPU takes that withdrawal as the sign that the vector is valid.

When the CPU removes the acknowledge, the block stops driving the data lines and goes back to idle. The vector is a static configuration input, set the way a switch bank would set it. Tri-state behaviour is modelled by a separate drive-enable output alongside the data value.

Top module: `irq_chain_node`

## Requirements
- R1: While reset is active and after it is released, irq_o is 0, bus_oe_o is 0 and bus_data_o is 0.
- R2: A one-cycle pulse on req_i while idle and while vec_i is at least 0x10 sets irq_o to 1 from the next cycle on. irq_o stays at 1 until the vector has been presented.
- R3: While the block is neither pending nor owning the grant, ack_out_o equals ack_in_i in the same cycle, with no clock delay.
- R4: Suppose the block is pending and ack_in_i is 1 in a cycle where it was 0 in the previous cycle. Then ack_out_o is 0 from that cycle on, and it stays 0 until the block is idle again.
- R5: One clock after the acknowledge is claimed, bus_oe_o is 1 and bus_data_o is {8'h00, vec_i}, while irq_o is still 1. In the cycle after that, irq_o is 0 and the vector is still driven.
- R6: If ack_in_i is 0 at a clock edge while the block owns the grant, then from the next cycle bus_oe_o is 0, bus_data_o is 0, irq_o is 0 and the acknowledge passes through again.
- R7: A block that becomes pending while ack_in_i is already 1 does not claim that acknowledge. It passes it on, stays pending, and claims only the next 0-to-1 change of ack_in_i.
- R8: A req_i pulse while vec_i is below 0x10 is ignored: irq_o stays 0 and acknowledges keep passing through.
- R9: A req_i pulse while the block is pending or owns the grant is ignored. Once the service ends, the block is idle, with irq_o at 0.
- R10: While bus_oe_o is 0, bus_data_o is all zeros. While it is 1, bits 15:8 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Local request pulse from the device's service logic |
| vec_i | input | 8 | Static vector setting (valid 0x10 to 0xFF) |
| ack_in_i | input | 1 | Acknowledge from the previous device in the chain |
| ack_out_o | output | 1 | Acknowledge toward the next device in the chain |
| irq_o | output | 1 | This device's contribution to the wired-OR request line |
| bus_oe_o | output | 1 | Drive enable for the data lines |
| bus_data_o | output | 16 | Value placed on the data lines while driving |

## Verification
The interesting coincidence is a local request and the arrival of an acknowledge landing in the same cycle. The bench provokes it by raising req_i and ack_in_i together, and also by raising req_i while an acknowledge is already high. In both cases the block must pass the grant along, remain pending, and claim only a later rising acknowledge. A second coincidence is the acknowledge falling in the very cycle the vector first appears. A behavioural model tracks every cycle and compares all outputs, so any early claim, leaked grant or lingering drive shows up in the cycle it happens.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PEND    = 2'd1,
    ST_GRANT   = 2'd2,
    ST_PRESENT = 2'd3
  } irqc_state_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_ack_edge.sv
module irqc_ack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic ack_rise_o
);
  logic ack_q;
  logic ack_d;
  logic ack_en;

  always_comb begin
    ack_en = 1'b1;
    ack_d  = ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ack_q <= 1'b0;
    else if (ack_en) ack_q <= ack_d;
  end

  assign ack_rise_o = ack_i & ~ack_q;
endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
  import irqc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        vec_ok_i,
  input  logic        ack_i,
  input  logic        ack_rise_i,
  output irqc_state_e state_o
);
  irqc_state_e state_q;
  irqc_state_e state_d;
  logic        state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i && vec_ok_i) state_d = ST_PEND;
      ST_PEND:    if (ack_rise_i)        state_d = ST_GRANT;
      ST_GRANT:   state_d = ack_i ? ST_PRESENT : ST_IDLE;
      ST_PRESENT: if (!ack_i)            state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irqc_drive.sv
module irqc_drive #(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              oe_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < VEC_W) begin : g_vec
      assign data_o[b] = oe_i & vec_i[b];
    end else begin : g_pad
      assign data_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
  import irqc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int VEC_W      = 8,
  parameter int VEC_MIN    = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              ack_in_i,
  output logic              ack_out_o,
  output logic              irq_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_data_o
);
  localparam logic [VEC_W-1:0] VecFloor = VEC_W'(VEC_MIN);

  logic        rst_int_n;
  logic        ack_rise;
  logic        vec_ok;
  logic        owns;
  irqc_state_e state;

  irqc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  irqc_ack_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .ack_i      (ack_in_i),
    .ack_rise_o (ack_rise)
  );

  assign vec_ok = (vec_i >= VecFloor);

  irqc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .req_i      (req_i),
    .vec_ok_i   (vec_ok),
    .ack_i      (ack_in_i),
    .ack_rise_i (ack_rise),
    .state_o    (state)
  );

  always_comb begin
    owns = (state == ST_GRANT) || (state == ST_PRESENT) ||
           ((state == ST_PEND) && ack_rise);
    ack_out_o = ack_in_i & ~owns;
    irq_o     = (state == ST_PEND) || (state == ST_GRANT);
    bus_oe_o  = (state == ST_GRANT) || (state == ST_PRESENT);
  end

  irqc_drive #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_drive (
    .oe_i   (bus_oe_o),
    .vec_i  (vec_i),
    .data_o (bus_data_o)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [VEC_W-1:0]  vec_i,
  input logic              ack_in_i,
  input logic              ack_out_o,
  input logic              irq_o,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] bus_data_o
);
  // R3
  ack_leak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_out_o |-> ack_in_i);
  // R4
  grant_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> !ack_out_o);
  // R6
  drive_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> $past(ack_in_i));
  // R5
  first_drive_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> irq_o);
  // R5
  drive_before_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(irq_o) && bus_oe_o) |-> $past(bus_oe_o));
  // R10
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (bus_data_o == '0));
  // R10
  vector_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (bus_data_o == DATA_W'(vec_i)));
endmodule

bind irq_chain_node irqc_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vec_i      (vec_i),
  .ack_in_i   (ack_in_i),
  .ack_out_o  (ack_out_o),
  .irq_o      (irq_o),
  .bus_oe_o   (bus_oe_o),
  .bus_data_o (bus_data_o)
);

// File: tb/tb_irq_chain_node.sv
`timescale 1ns/1ps
module tb_irq_chain_node;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  vec_i = 8'h5A;
  logic        ack_in_i = 1'b0;
  logic        ack_out_o;
  logic        irq_o;
  logic        bus_oe_o;
  logic [15:0] bus_data_o;

  irq_chain_node dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .vec_i(vec_i),
    .ack_in_i(ack_in_i), .ack_out_o(ack_out_o), .irq_o(irq_o),
    .bus_oe_o(bus_oe_o), .bus_data_o(bus_data_o)
  );

  always #4 clk_i = ~clk_i;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model: 0 idle, 1 waiting, 2 first drive cycle, 3 vector valid
  int m_st = 0;
  bit m_ackp = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_st   <= 0;
      m_ackp <= 0;
    end else begin
      m_ackp <= ack_in_i;
      if (m_st == 0 && req_i && vec_i >= 8'h10) m_st <= 1;
      else if (m_st == 1 && ack_in_i && !m_ackp) m_st <= 2;
      else if (m_st == 2) m_st <= ack_in_i ? 3 : 0;
      else if (m_st == 3 && !ack_in_i) m_st <= 0;
    end
  end

  function automatic logic [18:0] model_out();
    bit claim, irq, oe, ao;
    logic [15:0] d;
    claim = (m_st >= 2) || (m_st == 1 && ack_in_i && !m_ackp);
    ao    = ack_in_i && !claim;
    irq   = (m_st == 1 || m_st == 2);
    oe    = (m_st >= 2);
    d     = oe ? {8'h00, vec_i} : 16'h0000;
    return {ao, irq, oe, d};
  endfunction

  always @(negedge clk_i) begin
    if (!done) begin
      logic [18:0] act, exp;
      act = {ack_out_o, irq_o, bus_oe_o, bus_data_o};
      exp = model_out();
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d actual %h expected %h", cur_req, cycles, act, exp);
      end
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      summary();
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #2;
    end
  endtask

  task automatic pulse_req();
    req_i = 1'b1;
    tick(1);
    req_i = 1'b0;
  endtask

  initial begin
    // R1: reset with acknowledge wiggling
    cur_req = "R1";
    tick(1);
    ack_in_i = 1'b1;
    tick(2);
    ack_in_i = 1'b0;
    tick(1);
    rst_ni = 1'b1;
    tick(4);
    #2 chk("R1", {irq_o, bus_oe_o, bus_data_o}, 32'h0);

    // R3: idle pass-through
    cur_req = "R3";
    ack_in_i = 1'b1;
    #1 chk("R3", ack_out_o, 1);
    tick(2);
    ack_in_i = 1'b0;
    #1 chk("R3", ack_out_o, 0);
    tick(2);

    // R2 R4 R5 R6: full service, vector 0x5A
    cur_req = "R2";
    vec_i = 8'h5A;
    pulse_req();
    #1 chk("R2", irq_o, 1);
    tick(2);
    cur_req = "R4";
    ack_in_i = 1'b1;
    #1 chk("R4", ack_out_o, 0);
    tick(1);
    cur_req = "R5";
    #1 chk("R5", {irq_o, bus_oe_o, bus_data_o}, {16'h3, 16'h005A});
    tick(1);
    #1 chk("R5", {irq_o, bus_oe_o, bus_data_o}, {16'h1, 16'h005A});
    tick(3);
    cur_req = "R6";
    ack_in_i = 1'b0;
    tick(1);
    #1 chk("R6", {irq_o, bus_oe_o, bus_data_o}, 32'h0);
    tick(2);

    // R7: request while acknowledge already passing, and coincident arrival
    cur_req = "R7";
    vec_i = 8'hFF;
    ack_in_i = 1'b1;
    tick(1);
    pulse_req();
    #1 chk("R7", {ack_out_o, irq_o}, 32'h3);
    tick(2);
    ack_in_i = 1'b0;
    tick(2);
    ack_in_i = 1'b1;
    #1 chk("R7", ack_out_o, 0);
    tick(4);
    ack_in_i = 1'b0;
    tick(2);
    req_i = 1'b1;
    ack_in_i = 1'b1;
    tick(1);
    req_i = 1'b0;
    #1 chk("R7", {ack_out_o, irq_o}, 32'h3);
    tick(2);
    ack_in_i = 1'b0;
    tick(1);
    ack_in_i = 1'b1;
    tick(3);
    ack_in_i = 1'b0;
    tick(2);

    // R6: acknowledge withdrawn in the first drive cycle; boundary vector 0x10
    cur_req = "R6";
    vec_i = 8'h10;
    pulse_req();
    tick(1);
    ack_in_i = 1'b1;
    tick(1);
    ack_in_i = 1'b0;
    #1 chk("R6", bus_data_o, 16'h0010);
    tick(1);
    #1 chk("R6", {irq_o, bus_oe_o}, 32'h0);
    tick(2);

    // R8: vector below range
    cur_req = "R8";
    vec_i = 8'h0F;
    pulse_req();
    tick(1);
    #1 chk("R8", irq_o, 0);
    ack_in_i = 1'b1;
    #1 chk("R8", ack_out_o, 1);
    tick(2);
    ack_in_i = 1'b0;
    tick(2);

    // R9 R10: extra request during service is dropped
    cur_req = "R9";
    vec_i = 8'hA3;
    pulse_req();
    tick(1);
    pulse_req();
    ack_in_i = 1'b1;
    tick(1);
    pulse_req();
    cur_req = "R10";
    #1 chk("R10", bus_data_o[15:8], 0);
    tick(2);
    ack_in_i = 1'b0;
    cur_req = "R9";
    tick(3);
    #1 chk("R9", irq_o, 0);
    ack_in_i = 1'b1;
    #1 chk("R9", ack_out_o, 1);
    tick(2);
    ack_in_i = 1'b0;
    tick(2);

    done = 1;
    summary();
    $finish;
  end
endmodule